// File: doc/BRIEF.md
# Halt, Wake-Up and Reset Sequencer

This block decides when a small microcontroller core may execute. It runs on an always-on clock that keeps ticking while the core is powered down. A halt request gates the system clock off and marks the power-down state. The block then watches for a way out: the external reset pin, a watchdog overflow, an interrupt request, or a falling edge on an enabled input-port bit. Every exit from power-down, every reset and the initial power-up are followed by a fixed settling window. During that window the system clock runs but the core stays stalled.

The block also records why the core was last restarted, in two status flags: a time-out flag (TO) and a power-down flag (PD). A watchdog overflow during power-down gives only a warm restart of the program counter and stack pointer. An external reset or a watchdog overflow while running gives a full cold reset. After an interrupt wake-up, the block issues a one-cycle take-interrupt strobe when the interrupt can be served. When it cannot, execution simply continues.

All request inputs are synchronous to `clk` except the reset pin, which is synchronized inside the block.

Top module: `halt_wake_seq`

## Requirements
- R1: While `porN` is low, `coldRst` is 1, TO and PD are 0 and `cpuRun` is 0. After `porN` rises, `cpuRun` stays 0 for 1024 clocks and is 1 in the clock after that.
- R2: A `haltReq` pulse while running pulses `wdtRestart` in the same cycle. On the next clock, `sysClkEn` goes 0, PD becomes 1 and TO becomes 0.
- R3: While running, `wdtClr` clears PD. A watchdog overflow while running sets TO, leaves PD unchanged, gives `coldRst` for exactly one clock and starts a settling window.
- R4: A watchdog overflow while halted pulses `warmRst` for one cycle, with `coldRst` staying 0. After the next clock, TO=1 and PD=1, and a settling window begins with no take-interrupt strobe.
- R5: Every exit from halt and every reset keeps `sysClkEn`=1 and `cpuRun`=0 for 1024 clocks before `cpuRun` returns to 1.
- R6: A 1-to-0 change on a bit of `portIn` whose `wakeMask` bit is 1 ends the halt. The same change on a bit whose mask bit is 0 leaves `sysClkEn` at 0.
- R7: An interrupt wake-up with `irqEn`=1 and `stackFull`=0 pulses `takeIrq` for one clock right after the 1024-clock window, and `cpuRun` rises one clock later. With `irqEn`=0 or `stackFull`=1, `takeIrq` stays 0 and `cpuRun` rises right after the window.
- R8: An interrupt request already at 1 when halt is entered does not end that halt.
- R9: `extResN` is seen through a two-flop synchronizer. When asserted, it drives `coldRst` and `cpuRun`=0. If the core was halted, TO becomes 0 and PD becomes 1. If the core was running, TO and PD are left unchanged. The 1024-clock window starts once the pin is released.
- R10: A watchdog overflow and a port wake in the same halted cycle are treated as a watchdog wake (warm reset, TO=1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| porN | input | 1 | Power-on reset, asynchronous, active low |
| extResN | input | 1 | External reset pin, asynchronous, active low |
| haltReq | input | 1 | Halt request from the core |
| wdtClr | input | 1 | Watchdog-clear strobe from the core |
| wdtOvf | input | 1 | Watchdog overflow strobe |
| portIn | input | 8 | Input-port sample |
| wakeMask | input | 8 | Per-bit wake enable for `portIn` |
| irqReq | input | 1 | Interrupt request flag |
| irqEn | input | 1 | Interrupt enable |
| stackFull | input | 1 | Call stack has no free entry |
| sysClkEn | output | 1 | System clock enable |
| cpuRun | output | 1 | Core may execute |
| coldRst | output | 1 | Full reset of the core |
| warmRst | output | 1 | Reset of program counter and stack pointer only |
| wdtRestart | output | 1 | Restart the watchdog count from zero |
| toFlag | output | 1 | Time-out status flag |
| pdFlag | output | 1 | Power-down status flag |
| takeIrq | output | 1 | Enter the interrupt routine |

## Verification
The assertions watch, on every cycle, the flag updates that follow halt entry, watchdog-clear and watchdog overflow. They also check that a warm restart is never paired with a cold one and that the take-interrupt strobe is a single cycle followed by execution. A counter in the checker confirms that `cpuRun` never rises before a full stalled window has elapsed.

Only the directed scenarios can show:
- which stimulus ends a halt and which is ignored (masked port bits, pre-pending interrupts);
- the exact cycle in which execution resumes;
- the flag pairs left by each kind of reset;
- the priority of the watchdog over a simultaneous port wake.

// File: rtl/hws_pkg.sv
package hws_pkg;

  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_HALT   = 2'd1,
    ST_SETTLE = 2'd2,
    ST_RESUME = 2'd3
  } seqState_t;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic haltEnter; // PD <= 1, TO <= 0
    logic pdClr;     // PD <= 0
    logic toSet;     // TO <= 1
    logic resWake;   // reset pin woke a halted core: TO <= 0, PD <= 1
    logic cold;      // drive cold reset on the next cycle
    logic cntClr;    // clear settle counter
    logic cntEn;     // advance settle counter
  } seqStrobe_t;

endpackage

// File: rtl/hws_datapath.sv
module hws_datapath
  import hws_pkg::*;
#(
  parameter int PORT_W        = 8,
  parameter int SETTLE_CYCLES = 1024,
  parameter int SYNC_STAGES   = 2
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              extResN,
  input  logic [PORT_W-1:0] portIn,
  input  logic [PORT_W-1:0] wakeMask,
  input  seqStrobe_t        strobe,
  output logic              resActive,
  output logic              portWake,
  output logic              settleDone,
  output logic              coldRst,
  output logic              toFlag,
  output logic              pdFlag
);

  localparam int CNT_W = (SETTLE_CYCLES > 2) ? $clog2(SETTLE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYCLES - 1);

  // Reset pin synchronizer; idles in the released state
  logic [SYNC_STAGES-1:0] resSync;
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) resSync <= '1;
    else       resSync <= {resSync[SYNC_STAGES-2:0], extResN};
  end
  assign resActive = !resSync[SYNC_STAGES-1];

  // Port falling-edge detection against the previous sample
  logic [PORT_W-1:0] portPrev;
  logic [PORT_W-1:0] fallBits;
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) portPrev <= '1;
    else       portPrev <= portIn;
  end

  for (genvar i = 0; i < PORT_W; i++) begin : g_fall
    assign fallBits[i] = wakeMask[i] & portPrev[i] & ~portIn[i];
  end
  assign portWake = |fallBits;

  // Settling window counter
  logic [CNT_W-1:0] settleCnt;
  always_ff @(posedge clk or negedge porN) begin
    if (!porN)             settleCnt <= '0;
    else if (strobe.cntClr) settleCnt <= '0;
    else if (strobe.cntEn)  settleCnt <= settleCnt + 1'b1;
  end
  assign settleDone = (settleCnt == CNT_LAST);

  // Cold reset output register
  logic coldQ;
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) coldQ <= 1'b1;
    else       coldQ <= strobe.cold;
  end
  assign coldRst = coldQ;

  // Reset-cause flags
  logic toQ, pdQ;
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      toQ <= 1'b0;
      pdQ <= 1'b0;
    end else if (strobe.resWake) begin
      toQ <= 1'b0;
      pdQ <= 1'b1;
    end else begin
      if (strobe.haltEnter) begin
        toQ <= 1'b0;
        pdQ <= 1'b1;
      end
      if (strobe.toSet) toQ <= 1'b1;
      if (strobe.pdClr) pdQ <= 1'b0;
    end
  end
  assign toFlag = toQ;
  assign pdFlag = pdQ;

endmodule

// File: rtl/hws_ctrl.sv
module hws_ctrl
  import hws_pkg::*;
(
  input  logic       clk,
  input  logic       porN,
  input  logic       haltReq,
  input  logic       wdtClr,
  input  logic       wdtOvf,
  input  logic       irqReq,
  input  logic       irqEn,
  input  logic       stackFull,
  input  logic       resActive,
  input  logic       portWake,
  input  logic       settleDone,
  output seqStrobe_t strobe,
  output logic       sysClkEn,
  output logic       cpuRun,
  output logic       warmRst,
  output logic       wdtRestart,
  output logic       takeIrq
);

  seqState_t state, stateNxt;
  logic irqBlock;
  logic takePend;
  logic irqWake;

  assign irqWake = irqReq && !irqBlock;

  always_comb begin
    stateNxt       = state;
    strobe         = '0;
    warmRst        = 1'b0;
    wdtRestart     = 1'b0;
    strobe.cntClr  = (state != ST_SETTLE) || resActive;
    strobe.cntEn   = (state == ST_SETTLE) && !resActive;
    if (resActive) begin
      stateNxt       = ST_SETTLE;
      strobe.cold    = 1'b1;
      strobe.resWake = (state == ST_HALT);
    end else begin
      unique case (state)
        ST_RUN: begin
          if (wdtOvf) begin
            strobe.toSet = 1'b1;
            strobe.cold  = 1'b1;
            stateNxt     = ST_SETTLE;
          end else if (haltReq) begin
            strobe.haltEnter = 1'b1;
            wdtRestart       = 1'b1;
            stateNxt         = ST_HALT;
          end else if (wdtClr) begin
            strobe.pdClr = 1'b1;
          end
        end
        ST_HALT: begin
          if (wdtOvf) begin
            strobe.toSet = 1'b1;
            warmRst      = 1'b1;
            stateNxt     = ST_SETTLE;
          end else if (irqWake || portWake) begin
            stateNxt = ST_SETTLE;
          end
        end
        ST_SETTLE: begin
          if (settleDone) stateNxt = takePend ? ST_RESUME : ST_RUN;
        end
        ST_RESUME: stateNxt = ST_RUN;
        default:   stateNxt = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) state <= ST_SETTLE;
    else       state <= stateNxt;
  end

  // Interrupts already requested at halt entry cannot wake
  always_ff @(posedge clk or negedge porN) begin
    if (!porN)                                      irqBlock <= 1'b0;
    else if (state == ST_RUN && stateNxt == ST_HALT) irqBlock <= irqReq;
  end

  // Whether the wake-up will enter the interrupt routine
  always_ff @(posedge clk or negedge porN) begin
    if (!porN)                                 takePend <= 1'b0;
    else if (resActive || state == ST_RUN)     takePend <= 1'b0;
    else if (state == ST_HALT && stateNxt == ST_SETTLE)
      takePend <= !wdtOvf && irqWake && irqEn && !stackFull;
  end

  assign sysClkEn = (state != ST_HALT);
  assign cpuRun   = (state == ST_RUN);
  assign takeIrq  = (state == ST_RESUME);

endmodule

// File: rtl/halt_wake_seq.sv
module halt_wake_seq
  import hws_pkg::*;
#(
  parameter int PORT_W        = 8,
  parameter int SETTLE_CYCLES = 1024,
  parameter int SYNC_STAGES   = 2
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              extResN,
  input  logic              haltReq,
  input  logic              wdtClr,
  input  logic              wdtOvf,
  input  logic [PORT_W-1:0] portIn,
  input  logic [PORT_W-1:0] wakeMask,
  input  logic              irqReq,
  input  logic              irqEn,
  input  logic              stackFull,
  output logic              sysClkEn,
  output logic              cpuRun,
  output logic              coldRst,
  output logic              warmRst,
  output logic              wdtRestart,
  output logic              toFlag,
  output logic              pdFlag,
  output logic              takeIrq
);

  seqStrobe_t strobe;
  logic resActive, portWake, settleDone;

  hws_ctrl uCtrl (
    .clk(clk), .porN(porN), .haltReq(haltReq), .wdtClr(wdtClr), .wdtOvf(wdtOvf),
    .irqReq(irqReq), .irqEn(irqEn), .stackFull(stackFull),
    .resActive(resActive), .portWake(portWake), .settleDone(settleDone),
    .strobe(strobe), .sysClkEn(sysClkEn), .cpuRun(cpuRun), .warmRst(warmRst),
    .wdtRestart(wdtRestart), .takeIrq(takeIrq)
  );

  hws_datapath #(
    .PORT_W(PORT_W), .SETTLE_CYCLES(SETTLE_CYCLES), .SYNC_STAGES(SYNC_STAGES)
  ) uDp (
    .clk(clk), .porN(porN), .extResN(extResN), .portIn(portIn), .wakeMask(wakeMask),
    .strobe(strobe), .resActive(resActive), .portWake(portWake),
    .settleDone(settleDone), .coldRst(coldRst), .toFlag(toFlag), .pdFlag(pdFlag)
  );

endmodule

// File: rtl/hws_checker.sv
module hws_checker #(
  parameter int SETTLE_CYCLES = 1024
) (
  input logic clk,
  input logic porN,
  input logic resActive,
  input logic haltReq,
  input logic wdtClr,
  input logic wdtOvf,
  input logic sysClkEn,
  input logic cpuRun,
  input logic coldRst,
  input logic warmRst,
  input logic takeIrq,
  input logic toFlag,
  input logic pdFlag
);

  localparam int SC_W = $clog2(SETTLE_CYCLES + 1) + 1;

  // Consecutive clocks with the clock on and the core stalled
  logic [SC_W-1:0] stallCnt;
  always_ff @(posedge clk or negedge porN) begin
    if (!porN)                                   stallCnt <= '0;
    else if (cpuRun || !sysClkEn || resActive)   stallCnt <= '0;
    else if (stallCnt < SC_W'(SETTLE_CYCLES))    stallCnt <= stallCnt + 1'b1;
  end

  // R2
  a_r2_halt_flags: assert property (@(posedge clk) disable iff (!porN)
    (cpuRun && haltReq && !wdtOvf && !resActive) |=> (pdFlag && !toFlag && !sysClkEn));

  // R3
  a_r3_clr_pd: assert property (@(posedge clk) disable iff (!porN)
    (cpuRun && wdtClr && !haltReq && !wdtOvf && !resActive) |=> !pdFlag);

  // R3
  a_r3_ovf_sets_to: assert property (@(posedge clk) disable iff (!porN)
    (wdtOvf && !resActive && (cpuRun || !sysClkEn)) |=> toFlag);

  // R4
  a_r4_warm_flags: assert property (@(posedge clk) disable iff (!porN)
    warmRst |=> (toFlag && pdFlag && sysClkEn && !cpuRun));

  // R4
  a_r4_warm_not_cold: assert property (@(posedge clk) disable iff (!porN)
    warmRst |-> !coldRst);

  // R5
  a_r5_full_window: assert property (@(posedge clk) disable iff (!porN)
    $rose(cpuRun) |-> (stallCnt >= SC_W'(SETTLE_CYCLES)));

  // R7
  a_r7_take_single: assert property (@(posedge clk) disable iff (!porN)
    takeIrq |=> (!takeIrq && cpuRun));

endmodule

bind halt_wake_seq hws_checker #(.SETTLE_CYCLES(SETTLE_CYCLES)) uChk (
  .clk(clk), .porN(porN), .resActive(resActive), .haltReq(haltReq),
  .wdtClr(wdtClr), .wdtOvf(wdtOvf), .sysClkEn(sysClkEn), .cpuRun(cpuRun),
  .coldRst(coldRst), .warmRst(warmRst), .takeIrq(takeIrq),
  .toFlag(toFlag), .pdFlag(pdFlag)
);

// File: tb/tb_halt_wake_seq.sv
module tb_halt_wake_seq;

  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 1024;

  logic clk = 1'b0;
  logic porN, extResN, haltReq, wdtClr, wdtOvf, irqReq, irqEn, stackFull;
  logic [7:0] portIn, wakeMask;
  logic sysClkEn, cpuRun, coldRst, warmRst, wdtRestart, toFlag, pdFlag, takeIrq;

  int nChecks = 0;
  int nFail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  halt_wake_seq dut (
    .clk(clk), .porN(porN), .extResN(extResN), .haltReq(haltReq), .wdtClr(wdtClr),
    .wdtOvf(wdtOvf), .portIn(portIn), .wakeMask(wakeMask), .irqReq(irqReq),
    .irqEn(irqEn), .stackFull(stackFull), .sysClkEn(sysClkEn), .cpuRun(cpuRun),
    .coldRst(coldRst), .warmRst(warmRst), .wdtRestart(wdtRestart),
    .toFlag(toFlag), .pdFlag(pdFlag), .takeIrq(takeIrq)
  );

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Called at the negedge after the clock that began a settling window
  task automatic waitSettle(input string tag, input bit expTake);
    check(tag, "sysClkEn in window", sysClkEn, 1'b1);
    check(tag, "cpuRun in window", cpuRun, 1'b0);
    step(SETTLE - 1);
    check(tag, "cpuRun at window end", cpuRun, 1'b0);
    step(1);
    if (expTake) begin
      check(tag, "takeIrq after window", takeIrq, 1'b1);
      check(tag, "cpuRun during take", cpuRun, 1'b0);
      step(1);
      check(tag, "takeIrq single", takeIrq, 1'b0);
      check(tag, "cpuRun after take", cpuRun, 1'b1);
    end else begin
      check(tag, "cpuRun after window", cpuRun, 1'b1);
      check(tag, "no takeIrq", takeIrq, 1'b0);
    end
  endtask

  task automatic enterHalt(input string tag);
    haltReq = 1'b1;
    #1;
    check(tag, "wdtRestart pulse", wdtRestart, 1'b1);
    step(1);
    haltReq = 1'b0;
    check(tag, "sysClkEn off", sysClkEn, 1'b0);
    check(tag, "PD set", pdFlag, 1'b1);
    check(tag, "TO clear", toFlag, 1'b0);
    check(tag, "wdtRestart gone", wdtRestart, 1'b0);
  endtask

  task automatic portWakeBit(input int b);
    portIn[b] = 1'b0;
    step(1);
    portIn = 8'hFF;
  endtask

  task automatic tPowerUp;
    step(2);
    check("R1", "coldRst in por", coldRst, 1'b1);
    check("R1", "TO in por", toFlag, 1'b0);
    check("R1", "PD in por", pdFlag, 1'b0);
    check("R1", "cpuRun in por", cpuRun, 1'b0);
    porN = 1'b1;
    waitSettle("R1", 1'b0);
    check("R1", "coldRst released", coldRst, 1'b0);
  endtask

  task automatic tPortWake;
    enterHalt("R2");
    step(3);
    check("R6", "still halted", sysClkEn, 1'b0);
    portWakeBit(5);
    waitSettle("R6", 1'b0);
    check("R6", "PD kept", pdFlag, 1'b1);
  endtask

  task automatic tWdtClr;
    wdtClr = 1'b1;
    step(1);
    wdtClr = 1'b0;
    check("R3", "PD cleared by wdtClr", pdFlag, 1'b0);
  endtask

  task automatic tMasked;
    wakeMask = 8'h01;
    enterHalt("R2");
    portWakeBit(3);
    step(3);
    check("R6", "masked bit ignored", sysClkEn, 1'b0);
    portWakeBit(0);
    waitSettle("R6", 1'b0);
    wakeMask = 8'hFF;
  endtask

  task automatic tIrq(input string tag, input logic en, input logic full, input bit expTake);
    irqEn = en; stackFull = full;
    enterHalt(tag);
    irqReq = 1'b1;
    step(1);
    waitSettle(tag, expTake);
    irqReq = 1'b0; irqEn = 1'b0; stackFull = 1'b0;
  endtask

  task automatic tIrqPending;
    irqReq = 1'b1; irqEn = 1'b1;
    step(1);
    enterHalt("R8");
    step(5);
    check("R8", "pending request no wake", sysClkEn, 1'b0);
    portWakeBit(1);
    waitSettle("R8", 1'b0);
    irqReq = 1'b0; irqEn = 1'b0;
  endtask

  task automatic tWdtHalt;
    enterHalt("R4");
    wdtOvf = 1'b1;
    #1;
    check("R4", "warmRst pulse", warmRst, 1'b1);
    check("R4", "no coldRst", coldRst, 1'b0);
    step(1);
    wdtOvf = 1'b0;
    check("R4", "warmRst single", warmRst, 1'b0);
    check("R4", "no coldRst after", coldRst, 1'b0);
    check("R4", "TO set", toFlag, 1'b1);
    check("R4", "PD set", pdFlag, 1'b1);
    waitSettle("R4", 1'b0);
  endtask

  task automatic tWdtRun;
    wdtClr = 1'b1;
    step(1);
    wdtClr = 1'b0;
    wdtOvf = 1'b1;
    step(1);
    wdtOvf = 1'b0;
    check("R3", "TO set running", toFlag, 1'b1);
    check("R3", "PD unchanged running", pdFlag, 1'b0);
    check("R3", "coldRst pulse", coldRst, 1'b1);
    check("R3", "no warmRst", warmRst, 1'b0);
    step(1);
    check("R3", "coldRst single", coldRst, 1'b0);
    step(SETTLE - 2);
    check("R3", "still stalled", cpuRun, 1'b0);
    step(1);
    check("R3", "running after window", cpuRun, 1'b1);
  endtask

  task automatic tExtRes(input bit fromHalt);
    string tag = "R9";
    if (fromHalt) enterHalt(tag);
    extResN = 1'b0;
    step(3);
    check(tag, "coldRst on pin", coldRst, 1'b1);
    check(tag, "cpuRun stalled", cpuRun, 1'b0);
    check(tag, "clock on", sysClkEn, 1'b1);
    if (fromHalt) begin
      check(tag, "TO after halt reset", toFlag, 1'b0);
      check(tag, "PD after halt reset", pdFlag, 1'b1);
    end else begin
      check(tag, "TO unchanged", toFlag, 1'b1);
      check(tag, "PD unchanged", pdFlag, 1'b0);
    end
    step(4);
    extResN = 1'b1;
    step(2);
    waitSettle(tag, 1'b0);
  endtask

  task automatic tPriority;
    irqEn = 1'b1;
    enterHalt("R10");
    wdtOvf = 1'b1;
    portIn[2] = 1'b0;
    #1;
    check("R10", "warm wins over port", warmRst, 1'b1);
    step(1);
    wdtOvf = 1'b0;
    portIn = 8'hFF;
    check("R10", "TO set", toFlag, 1'b1);
    waitSettle("R10", 1'b0);
    irqEn = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    nChecks++;
    $display("FAIL watchdog all-requirements actual=hung expected=finished");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    porN = 1'b0; extResN = 1'b1; haltReq = 1'b0; wdtClr = 1'b0; wdtOvf = 1'b0;
    irqReq = 1'b0; irqEn = 1'b0; stackFull = 1'b0;
    portIn = 8'hFF; wakeMask = 8'hFF;
    tPowerUp();
    tPortWake();
    tWdtClr();
    tMasked();
    tIrq("R7", 1'b1, 1'b0, 1'b1);
    tIrq("R7", 1'b1, 1'b1, 1'b0);
    tIrq("R7", 1'b0, 1'b0, 1'b0);
    tIrqPending();
    tWdtHalt();
    tWdtRun();
    tExtRes(1'b0);
    tExtRes(1'b1);
    tPriority();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule